// File: doc/BRIEF.md
# Modem Line Status and Change Tracker

This block keeps the modem status byte of a 16550-style serial port. The upper half of the byte shows the present level of four modem input lines, and the lower half holds one sticky change flag for each line. A flag is set when its line changes level, and it can also be set directly by an incoming value. It stays set until the host reads the byte. While any flag is set, the block raises an interrupt request to the port's interrupt arbiter.

There are three sources of updates. Each line has its own event input, a valid strobe and a level. The host can also write a whole byte. These updates are merged in a single cycle. A host read strobe returns the byte as it stood before the read, and the read clears the change flags on the next clock edge. A flag raised by an update in the same cycle as the read survives the clear.

Top module: `modem_status_tracker`

## Requirements
- R1: After reset the register reads 0x00 and the interrupt request is low.
- R2: The register layout is as follows. Bit 7 is carrier detect, bit 6 is ring indicator, bit 5 is data set ready and bit 4 is clear to send. Bits 3, 2, 1 and 0 are the change flags for those same lines, in the same order. Line event index 3..0 maps to bits 7..4 and to bits 3..0.
- R3: When an update changes a status bit, the matching change flag is 1 after the clock edge.
- R4: A change flag that is 1 stays 1 across any update when no read strobe is present in that cycle.
- R5: A host write sets bits 7:4 to write data bits 7:4. Each change flag becomes the OR of its old value, the status change it saw and write data bits 3:0.
- R6: A line event with level 1 sets that line's status bit and its change flag. A line event with level 0 clears the status bit. In that case the flag is set only if the bit was 1 before, and is otherwise kept at its earlier value.
- R7: While the read strobe is high, the read data shows the value held before the edge. After the edge, bits 3:0 are 0 and bits 7:4 are unchanged, provided no update occurs in that cycle.
- R8: A change flag raised by an update in the same cycle as a read is 1 after the edge.
- R9: The interrupt request is high exactly when at least one change flag is 1.
- R10: When a host write and a line event fall in the same cycle, the event's level decides that line's status bit. The flags supplied by the write and by the event are both kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| line_vld | input | NUM_LINES | Per-line event strobe |
| line_lvl | input | NUM_LINES | Per-line level carried by the event |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 2*NUM_LINES | Host write value (status in upper half, flags in lower half) |
| rd_en | input | 1 | Host read strobe; clears the flags at the edge |
| rd_data | output | 2*NUM_LINES | Register value |
| irq | output | 1 | Modem-status interrupt request |

## Verification
The key case is a read-to-clear that lands in the same cycle as an update that raises a flag. The clear must not take away that new flag. The bench produces this case directly: it asserts ring indicator while the read strobe is high. It then checks two things: the read data still shows the pre-read byte, and after the edge the byte is 0x44 with the interrupt still raised. A sweep of 4096 cycles then combines writes, events and reads in every pairing, and compares each cycle against an arithmetic model of the merge rule.

// File: rtl/msr_pkg.sv
package msr_pkg;
   typedef enum int {
      LINE_CTS     = 0,
      LINE_DSR     = 1,
      LINE_RING    = 2,
      LINE_CARRIER = 3
   } line_idx_e;

   localparam int STD_LINES = 4;
endpackage

// File: rtl/msr_line_slice.sv
module msr_line_slice (
   input  logic cur_state,
   input  logic cur_flag,
   input  logic rd_clr,
   input  logic wr_en,
   input  logic wr_state,
   input  logic wr_flag,
   input  logic ev_vld,
   input  logic ev_lvl,
   output logic nxt_state,
   output logic nxt_flag
);
   logic base_state;
   logic supplied;
   logic kept;

   always_comb begin
      base_state = wr_en  ? wr_state : cur_state;
      nxt_state  = ev_vld ? ev_lvl   : base_state;
      supplied   = (wr_en & wr_flag) | (ev_vld & ev_lvl);
      kept       = cur_flag & ~rd_clr;
      nxt_flag   = kept | (cur_state ^ nxt_state) | supplied;
   end
endmodule

// File: rtl/msr_store.sv
module msr_store #(
   parameter int                WIDTH     = 8,
   parameter logic [WIDTH-1:0]  RESET_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n) q <= RESET_VAL;
      else        q <= d;
   end
endmodule

// File: rtl/modem_status_tracker.sv
module modem_status_tracker #(
   parameter int NUM_LINES = msr_pkg::STD_LINES,
   parameter bit IRQ_REG   = 1'b0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_LINES-1:0]   line_vld,
   input  logic [NUM_LINES-1:0]   line_lvl,
   input  logic                   wr_en,
   input  logic [2*NUM_LINES-1:0] wr_data,
   input  logic                   rd_en,
   output logic [2*NUM_LINES-1:0] rd_data,
   output logic                   irq
);
   localparam int W = 2 * NUM_LINES;

   generate
      if (NUM_LINES < 1) begin : g_bad_cfg
         $error("modem_status_tracker: NUM_LINES must be at least 1");
      end
   endgenerate

   logic [W-1:0]         reg_q;
   logic [W-1:0]         reg_d;
   logic [NUM_LINES-1:0] st_cur, fl_cur, st_nxt, fl_nxt;

   assign st_cur = reg_q[W-1:NUM_LINES];
   assign fl_cur = reg_q[NUM_LINES-1:0];

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      msr_line_slice u_slice (
         .cur_state (st_cur[i]),
         .cur_flag  (fl_cur[i]),
         .rd_clr    (rd_en),
         .wr_en     (wr_en),
         .wr_state  (wr_data[NUM_LINES+i]),
         .wr_flag   (wr_data[i]),
         .ev_vld    (line_vld[i]),
         .ev_lvl    (line_lvl[i]),
         .nxt_state (st_nxt[i]),
         .nxt_flag  (fl_nxt[i])
      );
   end

   assign reg_d = {st_nxt, fl_nxt};

   msr_store #(.WIDTH(W), .RESET_VAL('0)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (reg_d),
      .q     (reg_q)
   );

   assign rd_data = reg_q;

   generate
      if (IRQ_REG) begin : g_irq_ff
         logic irq_q;
         always_ff @(posedge clk) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= |fl_nxt;
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = |fl_cur;
      end
   endgenerate
endmodule

// File: rtl/msr_checker.sv
module msr_checker #(
   parameter int NUM_LINES = 4
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [NUM_LINES-1:0]   line_vld,
   input logic [NUM_LINES-1:0]   line_lvl,
   input logic                   wr_en,
   input logic                   rd_en,
   input logic [2*NUM_LINES-1:0] rd_data,
   input logic                   irq
);
   localparam int W = 2 * NUM_LINES;

   AST_CHANGE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (((rd_data[W-1:NUM_LINES] ^ $past(rd_data[W-1:NUM_LINES])) & ~rd_data[NUM_LINES-1:0]) == '0)); // R3

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> ((rd_data[NUM_LINES-1:0] & $past(rd_data[NUM_LINES-1:0])) == $past(rd_data[NUM_LINES-1:0]))); // R4

   AST_EVENT_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (((rd_data[W-1:NUM_LINES] ^ $past(line_lvl)) & $past(line_vld)) == '0)); // R6

   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !wr_en && line_vld == '0) |=> (rd_data[NUM_LINES-1:0] == '0 && $stable(rd_data[W-1:NUM_LINES]))); // R7

   AST_IRQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !wr_en && line_vld == '0) |=> !irq); // R9

   AST_IRQ_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
      (line_vld & line_lvl) != '0 |=> irq); // R9
endmodule

bind modem_status_tracker msr_checker #(.NUM_LINES(NUM_LINES)) u_msr_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .line_vld (line_vld),
   .line_lvl (line_lvl),
   .wr_en    (wr_en),
   .rd_en    (rd_en),
   .rd_data  (rd_data),
   .irq      (irq)
);

// File: tb/sim_modem_status_tracker.sv
module sim_modem_status_tracker;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] line_vld = '0;
   logic [3:0] line_lvl = '0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic       rd_en = 1'b0;
   logic [7:0] rd_data;
   logic       irq;

   int n_run = 0;
   int n_fail = 0;
   logic [7:0] model = 8'h00;

   always #5 clk = ~clk;

   modem_status_tracker #(.NUM_LINES(4)) u0 (
      .clk(clk), .rst_n(rst_n), .line_vld(line_vld), .line_lvl(line_lvl),
      .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
      .rd_data(rd_data), .irq(irq)
   );

   function automatic logic [7:0] next_val(input logic [7:0] c, input logic we,
      input logic [7:0] wd, input logic [3:0] ev, input logic [3:0] el, input logic rd);
      logic [3:0] st, sup, fl;
      st  = we ? wd[7:4] : c[7:4];
      st  = (st & ~ev) | (el & ev);
      sup = (we ? wd[3:0] : 4'h0) | (ev & el);
      fl  = (rd ? 4'h0 : c[3:0]) | (c[7:4] ^ st) | sup;
      return {st, fl};
   endfunction

   task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %02h expected %02h", tag, got, exp);
      end
   endtask

   // drive one cycle; read data is checked against the pre-edge value
   task automatic step(input logic we, input logic [7:0] wd, input logic [3:0] ev,
                       input logic [3:0] el, input logic rd, input string tag);
      @(negedge clk);
      wr_en = we; wr_data = wd; line_vld = ev; line_lvl = el; rd_en = rd;
      #1;
      chk({tag, " R7 pre-read value"}, rd_data, model);
      model = next_val(model, we, wd, ev, el, rd);
      @(negedge clk);
      wr_en = 1'b0; line_vld = '0; line_lvl = '0; rd_en = 1'b0;
      chk({tag, " state"}, rd_data, model);
      chk({tag, " R9 irq"}, {7'h0, irq}, {7'h0, model[3:0] != 4'h0});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      chk("R1 reset value", rd_data, 8'h00);
      chk("R1 reset irq", {7'h0, irq}, 8'h00);

      step(0, 8'h00, 4'h8, 4'h8, 0, "R6 carrier up");
      chk("R2 R6 carrier bits 7 and 3", rd_data, 8'h88);
      chk("R9 irq on flag", {7'h0, irq}, 8'h01);
      step(0, 8'h00, 4'h0, 4'h0, 1, "R7 read");
      chk("R7 flags cleared", rd_data, 8'h80);
      chk("R9 irq after read", {7'h0, irq}, 8'h00);
      step(0, 8'h00, 4'h8, 4'h0, 0, "R6 carrier down");
      chk("R6 R3 drop flags change", rd_data, 8'h08);
      step(0, 8'h00, 4'h0, 4'h0, 1, "R7 read2");
      step(0, 8'h00, 4'h8, 4'h0, 0, "R6 down again");
      chk("R6 no change no flag", rd_data, 8'h00);
      step(0, 8'h00, 4'h1, 4'h1, 0, "R4 cts up");
      step(0, 8'h00, 4'h2, 4'h2, 0, "R4 dsr up");
      chk("R4 R2 flags sticky", rd_data, 8'h33);
      step(0, 8'h05, 4'h0, 4'h0, 1, "R7 read3");
      step(1, 8'h05, 4'h0, 4'h0, 0, "R5 write");
      chk("R5 R3 write merge", rd_data, 8'h07);
      step(0, 8'h00, 4'h4, 4'h4, 1, "R8 read with ring");
      chk("R8 flag kept through read", rd_data, 8'h44);
      chk("R8 irq kept", {7'h0, irq}, 8'h01);
      step(0, 8'h00, 4'h0, 4'h0, 1, "R7 read4");
      step(1, 8'hF0, 4'h4, 4'h0, 0, "R10 write with event");
      chk("R10 event overrides write", rd_data, 8'hBF);

      for (int a = 0; a < 256; a++) begin
         for (int c = 0; c < 16; c++) begin
            logic [7:0] av = a[7:0];
            logic [3:0] cv = c[3:0];
            step(cv[0], av, cv ^ av[3:0], av[7:4] ^ cv, cv[3] ^ av[0], "R3 R4 R5 R8 R10 sweep");
         end
      end

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule